// File: doc/BRIEF.md
# Paged Register Bridge Access Sequencer

This block sits on the host side of a management link. It takes one request (page, register offset, width code, direction and up to 64 bits of write data) and expands it into the run of 16-bit clause-22 register transactions that a paged register bridge behind a fixed PHY address expects. The bridge exposes a page select register at 0x10, a command/status register at 0x11 and four 16-bit data words at 0x18 to 0x1B.

For a write, the data words go out first, then the page select if needed, then the command word. For a read, the page select goes out if needed, then the command word, and the data words are fetched afterwards. In both cases the sequencer polls the command register until the bridge clears its operation bits. It remembers the last page it selected and skips a page write when the page has not changed. It ends every request with a one-cycle done pulse, an error flag and, for reads, the assembled value.

Top module: `paged_reg_seq`

## Requirements
- R1: The page register (0x10) is written only when the requested page differs from the remembered page, with the value {page, 8'h01}. A page that was written successfully becomes the remembered page.
- R2: After reset the remembered page is 0xFF, so the first request to any other page writes the page register.
- R3: The command word written to register 0x11 is {offset, 6'b0, op}, with op = 2'b01 for a write and 2'b10 for a read. Each management request holds its register, direction and data stable until the responder's done.
- R4: After the command, register 0x11 is read until bits 1:0 are both zero, for at most MAX_POLLS reads, with more than POLL_WAIT idle cycles between one read's done and the next read.
- R5: If bits 1:0 are still nonzero on read number MAX_POLLS, the request ends with the error flag set, read data zero and no data word read.
- R6: Width code 0 means 8 bits, 1 means 16, 2 means 32, 3 means 48, 4 to 7 mean 64. A write sends 1, 1, 2, 3 or 4 data words, to 0x18 upward, 16 bits each taken from the low end, before any page or command write.
- R7: A read of 32 bits or more fetches data words from the highest one down to 0x18 and returns them concatenated, the word from 0x18 in bits 15:0.
- R8: An 8-bit read returns only the low byte of word 0x18, zero-extended. A 16-bit read returns word 0x18.
- R9: A management write that returns an error aborts the request at once with the error flag set. A failed page write does not change the remembered page.
- R10: Every management transaction uses the PHY address given by parameter PHY_ADDR (default 30).
- R11: A request is taken only when req_ready is high; a request presented while busy is ignored. Each accepted request produces exactly one rsp_done pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_page | input | 8 | Bridge page |
| req_reg | input | 8 | Register offset within the page |
| req_width | input | 3 | Width code (0:8, 1:16, 2:32, 3:48, 4-7:64 bits) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 64 | Write value |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error flag, valid with rsp_done |
| rsp_rdata | output | 64 | Read value, valid with rsp_done |
| mg_valid | output | 1 | Management transaction requested, held until mg_done |
| mg_phy | output | 5 | Management PHY address |
| mg_reg | output | 5 | Management register number |
| mg_write | output | 1 | 1 for management write |
| mg_wdata | output | 16 | Management write data |
| mg_done | input | 1 | Management transaction finished (one cycle) |
| mg_err | input | 1 | Management write failed, valid with mg_done |
| mg_rdata | input | 16 | Management read data, valid with mg_done |

## Verification
The poll that comes back clear on the very last allowed read and the retry limit running out are decided on the same poll response, so the busy count in the behavioural responder is set to exactly MAX_POLLS-1 and then to MAX_POLLS; the first must finish cleanly after MAX_POLLS reads and return data, the second must flag an error after the same number of reads with no data fetched. A second pairing is the page cache update against a management write failure: the responder fails the page write, and the next request to that same page must write the page register again.

// File: rtl/prs_pkg.sv
// Package: shared constants, state type and width decoding for the
// paged register bridge sequencer. Assumes a 16-bit management data path.
package prs_pkg;
    localparam int MG_DW     = 16;
    localparam int MAX_WORDS = 4;
    localparam int DATA_W    = MG_DW * MAX_WORDS;
    localparam int WIDX_W    = $clog2(MAX_WORDS);

    localparam logic [4:0] RA_PAGE  = 5'h10;
    localparam logic [4:0] RA_CMD   = 5'h11;
    localparam logic [4:0] RA_DATA0 = 5'h18;

    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DWR,
        S_PAGE,
        S_CMD,
        S_POLL,
        S_WAIT,
        S_DRD,
        S_FIN
    } seq_state_e;

    // Index of the highest data word moved for a width code.
    function automatic logic [WIDX_W-1:0] top_word(input logic [2:0] code);
        case (code)
            3'd0, 3'd1: top_word = WIDX_W'(0);
            3'd2:       top_word = WIDX_W'(1);
            3'd3:       top_word = WIDX_W'(2);
            default:    top_word = WIDX_W'(3);
        endcase
    endfunction
endpackage

// File: rtl/prs_page_cache.sv
// Page cache: remembers the last page successfully selected on the bridge.
// Assumes the reset value is a page that is never used in normal traffic.
module prs_page_cache #(
    parameter logic [7:0] RESET_PAGE = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set,
    input  logic [7:0] page_in,
    output logic [7:0] page_q
);
    // Load a new page on a successful page write.
    always_ff @(posedge clk) begin
        if (!rst_n)   page_q <= RESET_PAGE;
        else if (set) page_q <= page_in;
    end
endmodule

// File: rtl/prs_poll_pacer.sv
// Poll pacer: counts busy status reads and times the gap before the next.
// Assumes start comes before the first poll of a request.
module prs_poll_pacer #(
    parameter int MAX_POLLS = 5,
    parameter int POLL_WAIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic busy_seen,
    output logic last_try,
    output logic wait_done
);
    localparam int AW = $clog2(MAX_POLLS + 2);
    localparam int WW = $clog2(POLL_WAIT + 2);

    logic [AW-1:0] tries;
    logic [WW-1:0] wcnt;

    // Count busy poll results within one request.
    always_ff @(posedge clk) begin
        if (!rst_n || start) tries <= '0;
        else if (busy_seen)  tries <= tries + AW'(1);
    end

    // Load the wait on a busy result, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             wcnt <= '0;
        else if (busy_seen)     wcnt <= WW'(POLL_WAIT);
        else if (wcnt != '0)    wcnt <= wcnt - WW'(1);
    end

    assign last_try  = (tries == AW'(MAX_POLLS - 1));
    assign wait_done = (wcnt == '0);
endmodule

// File: rtl/prs_word_acc.sv
// Word accumulator: shifts 16-bit words in at the low end, so feeding the
// highest word first leaves word 0 in bits 15:0.
module prs_word_acc
    import prs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic [MG_DW-1:0]  word_in,
    output logic [DATA_W-1:0] acc
);
    // Clear at request start, shift on each data word read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else if (shift)    acc <= {acc[DATA_W-MG_DW-1:0], word_in};
    end
endmodule

// File: rtl/paged_reg_seq.sv
// Paged register bridge sequencer: expands one request into page select,
// data word, command and status poll transactions on a management port.
// Assumes the responder holds mg_done for one cycle per mg_valid request.
module paged_reg_seq
    import prs_pkg::*;
#(
    parameter int PHY_ADDR  = 30,
    parameter int MAX_POLLS = 5,
    parameter int POLL_WAIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_page,
    input  logic [7:0]        req_reg,
    input  logic [2:0]        req_width,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mg_valid,
    output logic [4:0]        mg_phy,
    output logic [4:0]        mg_reg,
    output logic              mg_write,
    output logic [MG_DW-1:0]  mg_wdata,
    input  logic              mg_done,
    input  logic              mg_err,
    input  logic [MG_DW-1:0]  mg_rdata
);
    seq_state_e        st;
    logic [7:0]        lat_page, lat_reg;
    logic [2:0]        lat_w;
    logic              lat_wr, fail;
    logic [DATA_W-1:0] lat_wdata;
    logic [WIDX_W-1:0] widx, lw;
    logic [7:0]        cur_page;
    logic [DATA_W-1:0] acc;
    logic              last_try, wait_done, accept, page_hit, req_hit;
    logic              page_set, poll_start, poll_busy, acc_shift, bits_clear;

    assign accept     = (st == S_IDLE) && req_valid;
    assign lw         = top_word(lat_w);
    assign page_hit   = (cur_page == lat_page);
    assign req_hit    = (cur_page == req_page);
    assign bits_clear = (mg_rdata[1:0] == 2'b00);
    assign page_set   = (st == S_PAGE) && mg_done && !mg_err;
    assign poll_start = (st == S_CMD) && mg_done;
    assign poll_busy  = (st == S_POLL) && mg_done && !bits_clear;
    assign acc_shift  = (st == S_DRD) && mg_done;

    prs_page_cache u_cache (
        .clk(clk), .rst_n(rst_n), .set(page_set),
        .page_in(lat_page), .page_q(cur_page)
    );

    prs_poll_pacer #(.MAX_POLLS(MAX_POLLS), .POLL_WAIT(POLL_WAIT)) u_pacer (
        .clk(clk), .rst_n(rst_n), .start(poll_start), .busy_seen(poll_busy),
        .last_try(last_try), .wait_done(wait_done)
    );

    prs_word_acc u_acc (
        .clk(clk), .rst_n(rst_n), .clr(accept), .shift(acc_shift),
        .word_in(mg_rdata), .acc(acc)
    );

    // Sequence the transactions of one request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            lat_page  <= '0;
            lat_reg   <= '0;
            lat_w     <= '0;
            lat_wr    <= 1'b0;
            lat_wdata <= '0;
            widx      <= '0;
            fail      <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    lat_page  <= req_page;
                    lat_reg   <= req_reg;
                    lat_w     <= req_width;
                    lat_wr    <= req_write;
                    lat_wdata <= req_wdata;
                    widx      <= '0;
                    fail      <= 1'b0;
                    if (req_write)    st <= S_DWR;
                    else if (req_hit) st <= S_CMD;
                    else              st <= S_PAGE;
                end
                S_DWR: if (mg_done) begin
                    if (mg_err) begin
                        fail <= 1'b1;
                        st   <= S_FIN;
                    end else if (widx == lw) begin
                        st <= page_hit ? S_CMD : S_PAGE;
                    end else begin
                        widx <= widx + WIDX_W'(1);
                    end
                end
                S_PAGE, S_CMD: if (mg_done) begin
                    if (mg_err) begin
                        fail <= 1'b1;
                        st   <= S_FIN;
                    end else begin
                        st <= (st == S_PAGE) ? S_CMD : S_POLL;
                    end
                end
                S_POLL: if (mg_done) begin
                    if (bits_clear) begin
                        widx <= lw;
                        st   <= lat_wr ? S_FIN : S_DRD;
                    end else if (last_try) begin
                        fail <= 1'b1;
                        st   <= S_FIN;
                    end else begin
                        st <= S_WAIT;
                    end
                end
                S_WAIT: if (wait_done) st <= S_POLL;
                S_DRD: if (mg_done) begin
                    if (widx == '0) st <= S_FIN;
                    else            widx <= widx - WIDX_W'(1);
                end
                S_FIN:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Drive the management request from the current state.
    always_comb begin
        mg_valid = 1'b0;
        mg_write = 1'b0;
        mg_reg   = RA_CMD;
        mg_wdata = '0;
        case (st)
            S_DWR: begin
                mg_valid = 1'b1;
                mg_write = 1'b1;
                mg_reg   = RA_DATA0 + 5'(widx);
                mg_wdata = lat_wdata[widx*MG_DW +: MG_DW];
            end
            S_PAGE: begin
                mg_valid = 1'b1;
                mg_write = 1'b1;
                mg_reg   = RA_PAGE;
                mg_wdata = {lat_page, 8'h01};
            end
            S_CMD: begin
                mg_valid = 1'b1;
                mg_write = 1'b1;
                mg_wdata = {lat_reg, 6'b0, lat_wr ? OP_WR : OP_RD};
            end
            S_POLL: mg_valid = 1'b1;
            S_DRD: begin
                mg_valid = 1'b1;
                mg_reg   = RA_DATA0 + 5'(widx);
            end
            default: ;
        endcase
    end

    // Present the response in the finishing cycle only.
    always_comb begin
        rsp_done  = (st == S_FIN);
        rsp_err   = (st == S_FIN) && fail;
        rsp_rdata = '0;
        if (st == S_FIN && !fail)
            rsp_rdata = (lat_w == 3'd0) ? DATA_W'(acc[7:0]) : acc;
    end

    assign req_ready = (st == S_IDLE);
    assign mg_phy    = 5'(PHY_ADDR);
endmodule

// File: rtl/prs_checker.sv
// Checker: protocol properties of the sequencer ports, bound to the top.
module prs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_done,
    input logic        rsp_err,
    input logic [63:0] rsp_rdata,
    input logic        mg_valid,
    input logic        mg_write,
    input logic [4:0]  mg_reg,
    input logic [15:0] mg_wdata,
    input logic        mg_done
);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r5_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_err) |-> (rsp_rdata == 64'd0));

    a_r1_page_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && mg_write && mg_reg == 5'h10) |-> (mg_wdata[7:0] == 8'h01));

    a_r3_cmd_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && mg_write && mg_reg == 5'h11)
        |-> ($countones(mg_wdata[1:0]) == 1 && mg_wdata[7:2] == 6'd0));

    a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && !mg_done)
        |=> (mg_valid && $stable(mg_reg) && $stable(mg_write) && $stable(mg_wdata)));
endmodule

bind paged_reg_seq prs_checker u_prs_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mg_valid(mg_valid), .mg_write(mg_write), .mg_reg(mg_reg),
    .mg_wdata(mg_wdata), .mg_done(mg_done)
);

// File: tb/paged_reg_seq_tb_top.sv
// Scoreboard bench with a behavioural bridge responder.
module paged_reg_seq_tb_top;
    localparam int PW = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_page = '0, req_reg = '0;
    logic [2:0] req_width = '0;
    logic [63:0] req_wdata = '0;
    logic req_ready, rsp_done, rsp_err;
    logic [63:0] rsp_rdata;
    logic mg_valid, mg_write;
    logic [4:0] mg_phy, mg_reg;
    logic [15:0] mg_wdata;
    logic mg_done = 1'b0, mg_err = 1'b0;
    logic [15:0] mg_rdata = '0;

    paged_reg_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_page(req_page), .req_reg(req_reg), .req_width(req_width),
        .req_write(req_write), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mg_valid(mg_valid),
        .mg_phy(mg_phy), .mg_reg(mg_reg), .mg_write(mg_write),
        .mg_wdata(mg_wdata), .mg_done(mg_done), .mg_err(mg_err),
        .mg_rdata(mg_rdata)
    );

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Responder model state.
    logic [63:0] mem [logic [15:0]];
    logic [15:0] dreg [4];
    logic [15:0] cmd_q = '0, last_cmd = '0, last_page_val = '0;
    logic [7:0]  rpage = '0;
    int busy_cfg = 0, busy_left = 0, fail_reg = -1;
    int page_wr_cnt = 0, poll_cnt = 0, bad_phy = 0;
    int ev_q[$];
    longint poll_t[$];
    longint cyc = 0;

    always @(posedge clk) cyc++;

    task automatic serve();
        logic [15:0] key;
        logic [63:0] v;
        int idx;
        if (mg_phy != 5'd30) bad_phy++;
        mg_err = 1'b0;
        mg_rdata = '0;
        idx = int'(mg_reg) - 'h18;
        if (mg_write) begin
            ev_q.push_back(256 + int'(mg_reg));
            if (fail_reg == int'(mg_reg)) begin
                mg_err = 1'b1;
                fail_reg = -1;
            end else if (mg_reg == 5'h10) begin
                rpage = mg_wdata[15:8];
                page_wr_cnt++;
                last_page_val = mg_wdata;
            end else if (mg_reg == 5'h11) begin
                last_cmd = mg_wdata;
                cmd_q = mg_wdata;
                busy_left = busy_cfg;
                key = {rpage, mg_wdata[15:8]};
                if (mg_wdata[1:0] == 2'b01)
                    mem[key] = {dreg[3], dreg[2], dreg[1], dreg[0]};
                else if (mg_wdata[1:0] == 2'b10) begin
                    v = mem.exists(key) ? mem[key] : 64'd0;
                    for (int i = 0; i < 4; i++) dreg[i] = v[i*16 +: 16];
                end
            end else if (idx >= 0 && idx < 4) begin
                dreg[idx] = mg_wdata;
            end
        end else begin
            ev_q.push_back(int'(mg_reg));
            if (mg_reg == 5'h11) begin
                poll_cnt++;
                poll_t.push_back(cyc);
                if (busy_left > 0) begin
                    busy_left--;
                    mg_rdata = cmd_q;
                end else begin
                    mg_rdata = cmd_q & 16'hFF00;
                end
            end else if (idx >= 0 && idx < 4) begin
                mg_rdata = dreg[idx];
            end
        end
        mg_done = 1'b1;
    endtask

    // Responder: two cycles of latency, one-cycle done.
    initial begin
        for (int i = 0; i < 4; i++) dreg[i] = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mg_valid) begin
                repeat (2) @(negedge clk);
                serve();
                @(negedge clk);
                mg_done = 1'b0;
                mg_err = 1'b0;
            end
        end
    end

    // Scoreboard.
    typedef struct {
        bit          err;
        logic [63:0] data;
        string       rq;
    } exp_t;
    exp_t sb_q[$];
    int done_cnt = 0;

    // Monitor: pop and compare on each done pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_done) begin
                done_cnt++;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(rsp_err == e.err, {e.rq, " err flag"}, 64'(rsp_err), 64'(e.err));
                    chk(rsp_rdata == e.data, {e.rq, " data"}, rsp_rdata, e.data);
                end
            end
        end
    end

    task automatic issue(input logic [7:0] pg, input logic [7:0] rg,
                         input logic [2:0] w, input logic wr,
                         input logic [63:0] wd, input bit eerr,
                         input logic [63:0] edata, input string rq);
        exp_t e;
        ev_q.delete();
        poll_t.delete();
        poll_cnt = 0;
        e.err = eerr; e.data = edata; e.rq = rq;
        sb_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_page = pg; req_reg = rg; req_width = w; req_write = wr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        summary();
        $finish;
    end

    initial begin
        bit gap_ok;
        int d0;
        mem[16'h0320] = 64'h1122334455667788;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
        chk(rsp_done == 1'b0 && mg_valid == 1'b0, "R11 reset quiet",
            64'({rsp_done, mg_valid}), 64'd0);

        // R2, R7: first access, 64-bit read
        issue(8'h03, 8'h20, 3'd4, 1'b0, '0, 1'b0, 64'h1122334455667788, "R7 read64");
        chk(page_wr_cnt == 1, "R2 first page write", 64'(page_wr_cnt), 64'd1);
        chk(last_page_val == 16'h0301, "R1 page word", 64'(last_page_val), 64'h0301);
        chk(last_cmd == 16'h2002, "R3 read command", 64'(last_cmd), 64'h2002);
        chk(ev_q.size() == 7 && ev_q[0] == 272 && ev_q[1] == 273 && ev_q[2] == 17 &&
            ev_q[3] == 27 && ev_q[4] == 26 && ev_q[5] == 25 && ev_q[6] == 24,
            "R7 word order", 64'(ev_q.size()), 64'd7);

        // R8, R1: narrower reads on the same page
        issue(8'h03, 8'h20, 3'd0, 1'b0, '0, 1'b0, 64'h88, "R8 read8");
        chk(page_wr_cnt == 1, "R1 page skipped", 64'(page_wr_cnt), 64'd1);
        issue(8'h03, 8'h20, 3'd1, 1'b0, '0, 1'b0, 64'h7788, "R8 read16");
        issue(8'h03, 8'h20, 3'd2, 1'b0, '0, 1'b0, 64'h55667788, "R7 read32");
        issue(8'h03, 8'h20, 3'd3, 1'b0, '0, 1'b0, 64'h334455667788, "R7 read48");
        issue(8'h03, 8'h20, 3'd7, 1'b0, '0, 1'b0, 64'h1122334455667788, "R6 code7 as 64");

        // R6: 48-bit write to a new page
        issue(8'h05, 8'h08, 3'd3, 1'b1, 64'hAAAABBBBCCCCDDDD, 1'b0, 64'd0, "R6 write48");
        chk(mem.exists(16'h0508) && mem[16'h0508][47:0] == 48'hBBBBCCCCDDDD,
            "R6 written value", mem.exists(16'h0508) ? 64'(mem[16'h0508][47:0]) : 64'd0,
            64'hBBBBCCCCDDDD);
        chk(ev_q.size() == 6 && ev_q[0] == 280 && ev_q[1] == 281 && ev_q[2] == 282 &&
            ev_q[3] == 272 && ev_q[4] == 273 && ev_q[5] == 17,
            "R6 write order", 64'(ev_q.size()), 64'd6);
        chk(last_cmd == 16'h0801, "R3 write command", 64'(last_cmd), 64'h0801);
        chk(page_wr_cnt == 2, "R1 page changed", 64'(page_wr_cnt), 64'd2);

        issue(8'h05, 8'h09, 3'd0, 1'b1, 64'h1234, 1'b0, 64'd0, "R6 write8");
        chk(ev_q.size() == 3 && ev_q[0] == 280 && ev_q[1] == 273,
            "R6 one word for 8 bits", 64'(ev_q.size()), 64'd3);

        // R4: clear on the last allowed poll
        busy_cfg = 4;
        issue(8'h05, 8'h08, 3'd3, 1'b0, '0, 1'b0, 64'hBBBBCCCCDDDD, "R4 last poll clear");
        chk(poll_cnt == 5, "R4 poll count", 64'(poll_cnt), 64'd5);
        gap_ok = 1'b1;
        for (int i = 1; i < poll_t.size(); i++)
            if (poll_t[i] - poll_t[i-1] <= PW) gap_ok = 1'b0;
        chk(gap_ok, "R4 poll spacing", 64'(gap_ok), 64'd1);

        // R5: still busy after the limit
        busy_cfg = 5;
        issue(8'h05, 8'h08, 3'd3, 1'b0, '0, 1'b1, 64'd0, "R5 poll timeout");
        chk(poll_cnt == 5, "R4 poll bound", 64'(poll_cnt), 64'd5);
        chk(ev_q.size() == 6, "R5 no data read", 64'(ev_q.size()), 64'd6);
        busy_cfg = 0;

        // R9: failed page write keeps the old page
        fail_reg = 16;
        issue(8'h07, 8'h01, 3'd1, 1'b0, '0, 1'b1, 64'd0, "R9 page fail");
        chk(ev_q.size() == 1, "R9 abort after page", 64'(ev_q.size()), 64'd1);
        issue(8'h07, 8'h01, 3'd1, 1'b0, '0, 1'b0, 64'd0, "R9 retry");
        chk(page_wr_cnt == 3 && ev_q.size() > 0 && ev_q[0] == 272,
            "R9 page rewritten", 64'(page_wr_cnt), 64'd3);

        // R9: failed data write stops before the command
        fail_reg = 25;
        issue(8'h07, 8'h02, 3'd2, 1'b1, 64'h11112222, 1'b1, 64'd0, "R9 data fail");
        chk(ev_q.size() == 2, "R9 no command", 64'(ev_q.size()), 64'd2);

        // R11: request while busy is ignored
        d0 = done_cnt;
        begin
            exp_t e;
            ev_q.delete();
            e.err = 1'b0; e.data = 64'd0; e.rq = "R11 busy request";
            sb_q.push_back(e);
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            req_page = 8'h07; req_reg = 8'h01; req_width = 3'd1; req_write = 1'b0;
            req_valid = 1'b1;
            @(negedge clk);
            req_page = 8'h09; req_width = 3'd4;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            while (!rsp_done) @(negedge clk);
            @(negedge clk);
        end
        chk(done_cnt == d0 + 1, "R11 one done", 64'(done_cnt), 64'(d0 + 1));
        chk(page_wr_cnt == 3, "R11 busy request ignored", 64'(page_wr_cnt), 64'd3);

        chk(bad_phy == 0, "R10 phy address", 64'(bad_phy), 64'd0);
        chk(sb_q.size() == 0, "R11 all responses seen", 64'(sb_q.size()), 64'd0);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule